// File: doc/BRIEF.md
# Half-Line Write-Combining Buffer

This block sits between a write-through data cache and the interconnect. Each word store from the processor side (a 30-bit word address, 32 bits of data and a 4-bit byte enable) is folded into an open burst. The open burst covers one 32-byte-aligned group of eight words. Stores to a word that the open burst already holds are merged byte by byte. A store that falls in a different group closes the open burst and hands it to a small queue of closed bursts. An issue stage takes bursts from the queue and presents them one word (beat) at a time with a valid/ready handshake.

A burst starts at the lowest word that was written and ends at the highest one. Its length is therefore anywhere from one to eight words. Words inside that span that were never written go out with an all-zero byte enable. A sync pulse forces the open burst out. The empty flag tells the cache controller when every accepted store has left the block. The processor side is held off only when the queue of closed bursts is full.

Top module: `wbuf_top`

## Requirements
- R1: In the cycle after reset is sampled high, `empty` is 1, `bst_valid` is 0 and `wr_ready` is 1.
- R2: Byte lane k of `wr_data` (bits 8k+7..8k) is written to byte k of the addressed word only when `wr_be[k]` is 1. A later store to the same word of the open burst replaces only its enabled bytes, and the beat's byte enable is the OR of all enables applied to that word.
- R3: A store whose group (`wr_addr[29:3]`) differs from the open burst's group closes the open burst and queues it, and that burst is issued without any sync.
- R4: The beats of one burst carry consecutive word addresses in ascending order, from the lowest to the highest written word index (`wr_addr[2:0]`). All beats share the same `bst_addr[29:3]`, and `bst_count` on every beat equals highest index minus lowest index plus one.
- R5: A word inside the span that was never written is issued with byte enable 0 and data 0. A store with an all-zero byte enable still marks its word as written, so it extends the span, but it changes no data.
- R6: A one-cycle `sync_req` closes the open burst so that it is issued. `empty` is 1 only when no burst is open, queued or being issued.
- R7: `wr_ready` is 0 only while the queue of `QDEPTH` closed bursts is full (or a sync is still closing the open burst). With fewer closed bursts waiting it stays 1.
- R8: `bst_first` is 1 on the first beat of a burst and `bst_last` on its final beat; a one-word burst has both set on its single beat.
- R9: While `bst_valid` is 1 and `bst_ready` is 0, the beat's address, data and byte enable hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_valid | input | 1 | Store request present |
| wr_addr | input | 30 | Word address of the store |
| wr_data | input | 32 | Store data, byte lane k at bits 8k+7..8k |
| wr_be | input | 4 | Per-byte write enable, zero allowed |
| wr_ready | output | 1 | Store accepted on this edge when high with wr_valid |
| sync_req | input | 1 | Pulse: push out the open burst |
| empty | output | 1 | No store left in the block |
| bst_valid | output | 1 | A burst beat is presented |
| bst_ready | input | 1 | Interconnect takes the beat |
| bst_addr | output | 30 | Word address of this beat |
| bst_count | output | 4 | Number of beats in the current burst |
| bst_first | output | 1 | First beat of a burst |
| bst_last | output | 1 | Last beat of a burst |
| bst_data | output | 32 | Beat data |
| bst_be | output | 4 | Beat byte enable |

## Verification
The hardest state to reach is a full queue of closed bursts, where the processor side must be stalled. It needs the interconnect to refuse beats while stores move across enough different groups to fill the issue register and every queue slot. The bench holds `bst_ready` low and writes four stores, each to its own group, so the open burst and two closed bursts stack up behind the one waiting in the issue stage. It checks `wr_ready` one step before and one step after the stall point. A long run of stores to overlapping words in three neighbouring groups, with random backpressure and occasional syncs, then exercises merging, gaps and zero enables against a scoreboard.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  localparam int WORD_W     = 32;
  localparam int BE_W       = WORD_W / 8;
  localparam int LINE_WORDS = 8;
  localparam int IDX_W      = $clog2(LINE_WORDS);
  localparam int CNT_W      = $clog2(LINE_WORDS + 1);
  localparam int VADDR_W    = 30;
  localparam int TAG_W      = VADDR_W - IDX_W;

  typedef struct packed {
    logic [TAG_W-1:0]                  tag;
    logic [LINE_WORDS-1:0]             mask;
    logic [LINE_WORDS-1:0][BE_W-1:0]   be;
    logic [LINE_WORDS-1:0][WORD_W-1:0] data;
  } burst_t;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [LINE_WORDS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = LINE_WORDS - 1; i >= 0; i--)
      if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] highest_set(input logic [LINE_WORDS-1:0] m);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < LINE_WORDS; i++)
      if (m[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] merge_bytes(input logic [WORD_W-1:0] old_w,
                                                    input logic [WORD_W-1:0] new_w,
                                                    input logic [BE_W-1:0]   en);
    logic [WORD_W-1:0] r;
    r = old_w;
    for (int k = 0; k < BE_W; k++)
      if (en[k]) r[8*k +: 8] = new_w[8*k +: 8];
    return r;
  endfunction
endpackage

// File: rtl/wbuf_collect.sv
module wbuf_collect
  import wbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [VADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [BE_W-1:0]    wr_be,
  output logic               wr_ready,
  input  logic               sync_req,
  input  logic               q_full,
  output logic               push,
  output burst_t             push_entry,
  output logic               open_o,
  output logic               flush_o
);
  logic   open_q, flush_q;
  burst_t cur_q, cur_d;
  logic [TAG_W-1:0] in_tag;
  logic [IDX_W-1:0] in_idx;
  logic accept, other_line, new_line, do_flush;

  assign in_tag     = wr_addr[VADDR_W-1:IDX_W];
  assign in_idx     = wr_addr[IDX_W-1:0];
  assign wr_ready   = !q_full && !flush_q;
  assign accept     = wr_valid && wr_ready;
  assign other_line = open_q && (cur_q.tag != in_tag);
  assign new_line   = accept && (!open_q || other_line);
  assign do_flush   = flush_q && open_q && !q_full;
  assign push       = (accept && other_line) || do_flush;
  assign push_entry = cur_q;
  assign open_o     = open_q;
  assign flush_o    = flush_q;

  always_comb begin
    cur_d = cur_q;
    if (new_line) begin
      cur_d      = '0;
      cur_d.tag  = in_tag;
    end
    if (accept) begin
      cur_d.mask[in_idx] = 1'b1;
      cur_d.data[in_idx] = merge_bytes(cur_d.data[in_idx], wr_data, wr_be);
      cur_d.be[in_idx]   = cur_d.be[in_idx] | wr_be;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q  <= 1'b0;
      flush_q <= 1'b0;
      cur_q   <= '0;
    end else begin
      cur_q <= cur_d;
      if (accept)        open_q <= 1'b1;
      else if (do_flush) open_q <= 1'b0;
      if (sync_req)                               flush_q <= 1'b1;
      else if (flush_q && (!open_q || !q_full))   flush_q <= 1'b0;
    end
  end

  // R3: a burst handed to the queue always holds at least one written word
  assert_push_nonempty_R3: assert property (@(posedge clk) disable iff (rst)
    push |-> (open_q && push_entry.mask != '0));
  // R6: a pending sync keeps the processor side out until the open burst has left
  assert_flush_blocks_R6: assert property (@(posedge clk) disable iff (rst)
    (flush_q && open_q) |-> !wr_ready || !open_q);
endmodule

// File: rtl/wbuf_fifo.sv
module wbuf_fifo
  import wbuf_pkg::*;
#(
  parameter int DEPTH = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   push,
  input  burst_t din,
  input  logic   pop,
  output burst_t dout,
  output logic   full,
  output logic   empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  burst_t          mem [DEPTH];
  logic [PW-1:0]   wp, rp;
  logic [CW-1:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + PW'(1);
      if (pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + PW'(1);
      case ({push, pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/wbuf_issue.sv
module wbuf_issue
  import wbuf_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               q_valid,
  input  burst_t             q_head,
  output logic               pop,
  output logic               busy,
  output logic               bst_valid,
  input  logic               bst_ready,
  output logic [VADDR_W-1:0] bst_addr,
  output logic [CNT_W-1:0]   bst_count,
  output logic               bst_first,
  output logic               bst_last,
  output logic [WORD_W-1:0]  bst_data,
  output logic [BE_W-1:0]    bst_be
);
  burst_t           cur_q;
  logic             busy_q;
  logic [IDX_W-1:0] idx_q, lo_q, hi_q;
  logic             fire, done, load;

  assign fire = busy_q && bst_ready;
  assign done = fire && (idx_q == hi_q);
  assign load = q_valid && (!busy_q || done);
  assign pop  = load;
  assign busy = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      busy_q <= 1'b0;
      idx_q  <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (load) begin
      cur_q  <= q_head;
      busy_q <= 1'b1;
      idx_q  <= lowest_set(q_head.mask);
      lo_q   <= lowest_set(q_head.mask);
      hi_q   <= highest_set(q_head.mask);
    end else if (done) begin
      busy_q <= 1'b0;
    end else if (fire) begin
      idx_q  <= idx_q + IDX_W'(1);
    end
  end

  assign bst_valid = busy_q;
  assign bst_addr  = {cur_q.tag, idx_q};
  assign bst_data  = cur_q.data[idx_q];
  assign bst_be    = cur_q.be[idx_q];
  assign bst_count = CNT_W'(hi_q) - CNT_W'(lo_q) + CNT_W'(1);
  assign bst_first = (idx_q == lo_q);
  assign bst_last  = (idx_q == hi_q);

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (bst_valid && !bst_ready) |=> bst_valid && $stable(bst_addr) &&
                                  $stable(bst_data) && $stable(bst_be));
  assert_ascend_R4: assert property (@(posedge clk) disable iff (rst)
    (fire && !bst_last) |=> bst_valid && (bst_addr == $past(bst_addr) + VADDR_W'(1)));
  assert_next_first_R8: assert property (@(posedge clk) disable iff (rst)
    (fire && bst_last) |=> (!bst_valid || bst_first));
endmodule

// File: rtl/wbuf_top.sv
module wbuf_top
  import wbuf_pkg::*;
#(
  parameter int QDEPTH = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_valid,
  input  logic [VADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0]  wr_data,
  input  logic [BE_W-1:0]    wr_be,
  output logic               wr_ready,
  input  logic               sync_req,
  output logic               empty,
  output logic               bst_valid,
  input  logic               bst_ready,
  output logic [VADDR_W-1:0] bst_addr,
  output logic [CNT_W-1:0]   bst_count,
  output logic               bst_first,
  output logic               bst_last,
  output logic [WORD_W-1:0]  bst_data,
  output logic [BE_W-1:0]    bst_be
);
  logic   q_full, q_empty, push, pop, open_w, flush_w, busy_w;
  burst_t push_entry, q_head;

  wbuf_collect u_collect (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_ready(wr_ready),
    .sync_req(sync_req), .q_full(q_full), .push(push),
    .push_entry(push_entry), .open_o(open_w), .flush_o(flush_w)
  );

  wbuf_fifo #(.DEPTH(QDEPTH)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .din(push_entry), .pop(pop),
    .dout(q_head), .full(q_full), .empty(q_empty)
  );

  wbuf_issue u_issue (
    .clk(clk), .rst(rst), .q_valid(!q_empty), .q_head(q_head), .pop(pop),
    .busy(busy_w), .bst_valid(bst_valid), .bst_ready(bst_ready),
    .bst_addr(bst_addr), .bst_count(bst_count), .bst_first(bst_first),
    .bst_last(bst_last), .bst_data(bst_data), .bst_be(bst_be)
  );

  assign empty = !open_w && !flush_w && q_empty && !busy_w;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (empty && !bst_valid && wr_ready));
  assert_empty_R6: assert property (@(posedge clk) disable iff (rst)
    empty |-> !bst_valid);
  assert_stall_R7: assert property (@(posedge clk) disable iff (rst)
    (!wr_ready && !flush_w) |-> q_full);
endmodule

// File: tb/wbuf_top_test.sv
module wbuf_top_test;
  localparam int AW = 30;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    wr_be = '0;
  logic          wr_ready;
  logic          sync_req = 1'b0;
  logic          empty;
  logic          bst_valid;
  logic          bst_ready;
  logic [AW-1:0] bst_addr;
  logic [3:0]    bst_count;
  logic          bst_first, bst_last;
  logic [31:0]   bst_data;
  logic [3:0]    bst_be;

  int checks = 0;
  int failures = 0;
  int bp_mode = 0;

  typedef struct packed {
    logic [AW-1:0] a;
    logic [31:0]   d;
    logic [3:0]    b;
    logic [3:0]    n;
    logic          f;
    logic          l;
  } beat_t;
  beat_t expq[$];

  logic          m_open = 1'b0;
  logic [AW-4:0] m_tag = '0;
  logic [7:0]    m_mask = '0;
  logic [31:0]   m_data [8];
  logic [3:0]    m_be [8];

  always #10 clk = ~clk;

  wbuf_top #(.QDEPTH(2)) uut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .wr_ready(wr_ready),
    .sync_req(sync_req), .empty(empty), .bst_valid(bst_valid),
    .bst_ready(bst_ready), .bst_addr(bst_addr), .bst_count(bst_count),
    .bst_first(bst_first), .bst_last(bst_last), .bst_data(bst_data),
    .bst_be(bst_be)
  );

  // backpressure; R9 holding of a refused beat is exercised by modes 1 and 2
  always @(negedge clk) begin
    if (bp_mode == 0)      bst_ready = 1'b1;
    else if (bp_mode == 1) bst_ready = 1'($urandom_range(0, 1));
    else                   bst_ready = 1'b0;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_close();
    int lo, hi;
    beat_t bt;
    if (!m_open) return;
    lo = -1; hi = 0;
    for (int i = 0; i < 8; i++) if (m_mask[i]) begin
      if (lo < 0) lo = i;
      hi = i;
    end
    for (int i = lo; i <= hi; i++) begin
      bt.a = {m_tag, 3'(i)};
      bt.d = m_data[i];
      bt.b = m_be[i];
      bt.n = 4'(hi - lo + 1);
      bt.f = (i == lo);
      bt.l = (i == hi);
      expq.push_back(bt);
    end
    m_open = 1'b0;
  endtask

  task automatic model_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b);
    int w;
    w = int'(a[2:0]);
    if (m_open && m_tag != a[AW-1:3]) model_close();
    if (!m_open) begin
      m_open = 1'b1;
      m_tag  = a[AW-1:3];
      m_mask = '0;
      for (int i = 0; i < 8; i++) begin m_data[i] = '0; m_be[i] = '0; end
    end
    m_mask[w] = 1'b1;
    for (int k = 0; k < 4; k++) if (b[k]) m_data[w][8*k +: 8] = d[8*k +: 8];
    m_be[w] = m_be[w] | b;
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] b);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d; wr_be = b;
    while (!wr_ready) @(negedge clk);
    @(posedge clk);
    model_write(a, d, b);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_sync();
    @(negedge clk);
    sync_req = 1'b1;
    @(negedge clk);
    sync_req = 1'b0;
    model_close();
  endtask

  task automatic drain();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #3;
      if (empty && expq.size() == 0) break;
    end
  endtask

  // scoreboard monitor
  initial begin
    beat_t e;
    forever begin
      @(negedge clk); #2;
      if (!rst && bst_valid && bst_ready) begin
        if (expq.size() == 0) begin
          chk("R4 unexpected beat", {34'd0, bst_addr}, 64'hFFFF_FFFF);
        end else begin
          e = expq.pop_front();
          chk("R4 beat address", {34'd0, bst_addr}, {34'd0, e.a});
          chk("R2 beat data", {32'd0, bst_data}, {32'd0, e.d});
          chk("R5 beat byte enable", {60'd0, bst_be}, {60'd0, e.b});
          chk("R4 burst count", {60'd0, bst_count}, {60'd0, e.n});
          chk("R8 first flag", {63'd0, bst_first}, {63'd0, e.f});
          chk("R8 last flag", {63'd0, bst_last}, {63'd0, e.l});
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #3;
    chk("R1 empty after reset", {63'd0, empty}, 64'd1);
    chk("R1 no beat after reset", {63'd0, bst_valid}, 64'd0);
    chk("R1 ready after reset", {63'd0, wr_ready}, 64'd1);

    // R2 merge, R5 zero enable and gap, R4 ordering, R6 sync
    do_write(30'h100, 32'h1111_1111, 4'hF);
    do_write(30'h103, 32'hAAAA_BBBB, 4'h3);
    do_write(30'h103, 32'hCCCC_DDDD, 4'hC);
    do_write(30'h101, 32'h5555_5555, 4'h0);
    do_write(30'h100, 32'h0000_9900, 4'h2);
    #3;
    chk("R6 not empty while burst open", {63'd0, empty}, 64'd0);
    do_sync();
    drain();
    chk("R6 empty after sync drain", {63'd0, empty}, 64'd1);
    chk("R6 all beats seen", 64'(expq.size()), 64'd0);

    // R3 line change closes the open burst without sync
    do_write(30'h205, 32'h0102_0304, 4'hF);
    do_write(30'h207, 32'h0506_0708, 4'h9);
    do_write(30'h300, 32'h0A0B_0C0D, 4'hF);
    drain();
    chk("R3 closed burst issued without sync", 64'(expq.size()), 64'd0);
    chk("R3 new line still open", {63'd0, empty}, 64'd0);
    do_sync();
    drain();

    // R8 single-word burst at the top index
    do_write(30'h3F7, 32'hDEAD_BEEF, 4'h5);
    do_sync();
    drain();
    chk("R8 single burst drained", {63'd0, empty}, 64'd1);

    // R7 stall only on a full queue
    bp_mode = 2;
    do_write(30'h400, 32'h0000_0001, 4'hF);
    do_write(30'h408, 32'h0000_0002, 4'hF);
    do_write(30'h410, 32'h0000_0003, 4'hF);
    #3;
    chk("R7 ready with one queued burst", {63'd0, wr_ready}, 64'd1);
    do_write(30'h418, 32'h0000_0004, 4'hF);
    #3;
    chk("R7 stalled with full queue", {63'd0, wr_ready}, 64'd0);
    repeat (3) @(negedge clk);
    #3;
    chk("R9 refused beat still valid", {63'd0, bst_valid}, 64'd1);
    chk("R9 refused beat address held", {34'd0, bst_addr}, {34'd0, 30'h400});
    bp_mode = 0;
    do_sync();
    drain();
    chk("R7 ready after draining", {63'd0, wr_ready}, 64'd1);

    // mixed stream with random backpressure
    bp_mode = 1;
    for (int i = 0; i < 60; i++) begin
      do_write(30'h500 + 30'($urandom_range(0, 23)), $urandom, 4'($urandom_range(0, 15)));
      if (i % 13 == 12) do_sync();
    end
    do_sync();
    drain();
    bp_mode = 0;
    chk("R6 empty after mixed stream", {63'd0, empty}, 64'd1);
    chk("R4 mixed stream all beats seen", 64'(expq.size()), 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule